// File: doc/BRIEF.md
# Forwarding and Load-Use Interlock Unit

This block holds the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it reads register specifiers and a few control bits from the four inter-stage registers. From these it picks a bypass source for each of the two ALU operands. When an instruction in decode needs the result of a load that is still in execute, it raises an interlock.

Each ALU operand has its own bypass picker. A picker compares the operand's source specifier, taken from the decode/execute register, with the destinations held in the execute/memory and memory/write-back registers. Only a stage that writes a register, and writes one other than register 0, counts as a producer. When both stages match, the younger value from execute/memory wins.

The load-use detector compares the destination of a load in decode/execute with both source fields of the instruction in fetch/decode. A small interlock state machine turns a detected hazard into one cycle of stall and bubble. The stall freezes the PC and the fetch/decode register. The bubble zeroes the control bits that enter decode/execute.

The machine has two states:
- `ILK_FLOW`: the normal state.
- `ILK_HELD`: the state for the cycle that follows a stall.

It has two transitions:
- `FLOW -> HELD`: taken when a hazard is seen.
- `HELD -> FLOW`: taken unconditionally.

Stall and bubble are driven only in `ILK_FLOW`. This guarantees that one stall never stretches past a single cycle.

Top module: `hz_forward_unit`

## Requirements
- R1: After reset, with all inputs low, both bypass selects read 2'b00 and stall and bubble are low.
- R2: An operand's select is 2'b10 (execute/memory result) when the execute/memory stage has its write enable set, a nonzero destination, and that destination equals the operand's source specifier.
- R3: An operand's select is 2'b01 (memory/write-back result) when only the memory/write-back stage matches under the same conditions.
- R4: When both stages match the same operand, the select is 2'b10: the younger result wins.
- R5: A stage with its write enable low, or with destination 0, never produces a match. The select is then 2'b00 (register file).
- R6: With a load in decode/execute whose destination equals the first or the second source field in fetch/decode, stall and bubble are both high in that same cycle.
- R7: With the load flag low, equal specifiers cause no stall and no bubble.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, stall and bubble are low even if the hazard inputs persist. In the cycle after that, the unit can stall again.
- R9: Operand A's select depends only on the decode/execute first source, and operand B's only on the second source. The two operands can take different selects in one cycle.
- R10: The bypass selects do not change because of a stall. During a stall they still reflect the decode/execute sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_rs | input | REG_ADDR_W | First source field of the instruction in fetch/decode |
| ifid_rt | input | REG_ADDR_W | Second source field of the instruction in fetch/decode |
| idex_rs | input | REG_ADDR_W | First source specifier in decode/execute (operand A) |
| idex_rt | input | REG_ADDR_W | Second source specifier in decode/execute (operand B, load destination) |
| idex_mem_read | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | REG_ADDR_W | Destination in execute/memory |
| exmem_reg_write | input | 1 | Execute/memory writes a register |
| memwb_rd | input | REG_ADDR_W | Destination in memory/write-back |
| memwb_reg_write | input | 1 | Memory/write-back writes a register |
| fwd_a | output | 2 | Operand A bypass select |
| fwd_b | output | 2 | Operand B bypass select |
| stall_fe | output | 1 | Hold PC and fetch/decode register |
| bubble_id | output | 1 | Zero the control bits entering decode/execute |

## Verification
The hardest case to reach from the ports is a load-use hazard that is still present in the cycle after a stall. A real pipeline never shows it, because the bubble has already replaced the load. The bench reaches it by holding the load flag and the matching specifiers steady across two clock edges. It then checks that stall drops in the held cycle and returns one cycle later. Priority is covered by driving the same destination into both producing stages at once. A separate case gives the two operands different producers in the same cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } byp_sel_e;

    typedef enum logic {
        ILK_FLOW = 1'b0,
        ILK_HELD = 1'b1
    } ilk_state_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hz_bypass_pick.sv
module hz_bypass_pick
    import hz_pkg::*;
#(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] exmem_rd,
    input  logic                  exmem_we,
    input  logic [REG_ADDR_W-1:0] memwb_rd,
    input  logic                  memwb_we,
    output byp_sel_e              sel
);

    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    logic ex_hit;
    logic wb_hit;

    always_comb begin
        ex_hit = exmem_we && (exmem_rd != ZERO_REG) && (exmem_rd == src);
        wb_hit = memwb_we && (memwb_rd != ZERO_REG) && (memwb_rd == src);
    end

    // Younger producer (execute/memory) wins over memory/write-back.
    always_comb begin
        unique casez ({ex_hit, wb_hit})
            2'b1?:   sel = SEL_EXMEM;
            2'b01:   sel = SEL_MEMWB;
            default: sel = SEL_RF;
        endcase
    end

endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] dec_src1,
    input  logic [REG_ADDR_W-1:0] dec_src2,
    input  logic [REG_ADDR_W-1:0] ld_dest,
    input  logic                  ld_valid,
    output logic                  hazard
);

    logic hit_src1;
    logic hit_src2;

    always_comb begin
        hit_src1 = (ld_dest == dec_src1);
        hit_src2 = (ld_dest == dec_src2);
        hazard   = ld_valid && (hit_src1 || hit_src2);
    end

endmodule

// File: rtl/hz_interlock_fsm.sv
module hz_interlock_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic hold,
    output logic squash
);

    ilk_state_e state_q;
    ilk_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ILK_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ILK_FLOW: if (hazard) state_d = ILK_HELD;
            ILK_HELD: state_d = ILK_FLOW;
            default:  state_d = ILK_FLOW;
        endcase
    end

    // Outputs
    always_comb begin
        hold   = 1'b0;
        squash = 1'b0;
        unique case (state_q)
            ILK_FLOW: begin
                hold   = hazard;
                squash = hazard;
            end
            ILK_HELD: begin
                hold   = 1'b0;
                squash = 1'b0;
            end
            default: begin
                hold   = 1'b0;
                squash = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hz_forward_unit.sv
module hz_forward_unit
    import hz_pkg::*;
#(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] ifid_rs,
    input  logic [REG_ADDR_W-1:0] ifid_rt,
    input  logic [REG_ADDR_W-1:0] idex_rs,
    input  logic [REG_ADDR_W-1:0] idex_rt,
    input  logic                  idex_mem_read,
    input  logic [REG_ADDR_W-1:0] exmem_rd,
    input  logic                  exmem_reg_write,
    input  logic [REG_ADDR_W-1:0] memwb_rd,
    input  logic                  memwb_reg_write,
    output logic [1:0]            fwd_a,
    output logic [1:0]            fwd_b,
    output logic                  stall_fe,
    output logic                  bubble_id
);

    logic [REG_ADDR_W-1:0] op_src [NUM_OPERANDS];
    byp_sel_e              op_sel [NUM_OPERANDS];
    logic                  lu_hazard;

    always_comb begin
        op_src[0] = idex_rs;
        op_src[1] = idex_rt;
    end

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_op
        hz_bypass_pick #(
            .REG_ADDR_W(REG_ADDR_W)
        ) u_pick (
            .src      (op_src[g]),
            .exmem_rd (exmem_rd),
            .exmem_we (exmem_reg_write),
            .memwb_rd (memwb_rd),
            .memwb_we (memwb_reg_write),
            .sel      (op_sel[g])
        );
    end

    hz_loaduse_detect #(
        .REG_ADDR_W(REG_ADDR_W)
    ) u_detect (
        .dec_src1 (ifid_rs),
        .dec_src2 (ifid_rt),
        .ld_dest  (idex_rt),
        .ld_valid (idex_mem_read),
        .hazard   (lu_hazard)
    );

    hz_interlock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (lu_hazard),
        .hold   (stall_fe),
        .squash (bubble_id)
    );

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

endmodule

// File: rtl/hz_forward_unit_chk.sv
module hz_forward_unit_chk #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] ifid_rs,
    input logic [REG_ADDR_W-1:0] ifid_rt,
    input logic [REG_ADDR_W-1:0] idex_rs,
    input logic [REG_ADDR_W-1:0] idex_rt,
    input logic                  idex_mem_read,
    input logic [REG_ADDR_W-1:0] exmem_rd,
    input logic                  exmem_reg_write,
    input logic [REG_ADDR_W-1:0] memwb_rd,
    input logic                  memwb_reg_write,
    input logic [1:0]            fwd_a,
    input logic [1:0]            fwd_b,
    input logic                  stall_fe,
    input logic                  bubble_id
);

    logic ex_a, wb_a, ex_b, wb_b;
    always_comb begin
        ex_a = exmem_reg_write && (exmem_rd != '0) && (exmem_rd == idex_rs);
        wb_a = memwb_reg_write && (memwb_rd != '0) && (memwb_rd == idex_rs);
        ex_b = exmem_reg_write && (exmem_rd != '0) && (exmem_rd == idex_rt);
        wb_b = memwb_reg_write && (memwb_rd != '0) && (memwb_rd == idex_rt);
    end

    a_r2_exmem_a: assert property (@(posedge clk) disable iff (!rst_n)
        ex_a |-> fwd_a == 2'b10);
    a_r4_exmem_b: assert property (@(posedge clk) disable iff (!rst_n)
        ex_b |-> fwd_b == 2'b10);
    a_r3_memwb_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_a && wb_a) |-> fwd_a == 2'b01);
    a_r5_regfile_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_b && !wb_b) |-> fwd_b == 2'b00);
    a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fe |-> idex_mem_read && (idex_rt == ifid_rs || idex_rt == ifid_rt));
    a_r6_bubble_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_id == stall_fe);
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fe |=> !stall_fe);

endmodule

bind hz_forward_unit hz_forward_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (.*);

// File: tb/hz_forward_unit_test.sv
module hz_forward_unit_test;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ifid_rs = '0, ifid_rt = '0, idex_rs = '0, idex_rt = '0;
    logic         idex_mem_read = 1'b0;
    logic [W-1:0] exmem_rd = '0, memwb_rd = '0;
    logic         exmem_reg_write = 1'b0, memwb_reg_write = 1'b0;
    logic [1:0]   fwd_a, fwd_b;
    logic         stall_fe, bubble_id;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hz_forward_unit #(.REG_ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_mem_read(idex_mem_read),
        .exmem_rd(exmem_rd), .exmem_reg_write(exmem_reg_write),
        .memwb_rd(memwb_rd), .memwb_reg_write(memwb_reg_write),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_fe(stall_fe), .bubble_id(bubble_id)
    );

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Reference select from the requirements (R2-R5)
    function automatic int ref_sel(logic [W-1:0] src, logic [W-1:0] erd, logic ewe,
                                   logic [W-1:0] wrd, logic wwe);
        if (ewe && erd != 0 && erd == src) return 2;
        if (wwe && wrd != 0 && wrd == src) return 1;
        return 0;
    endfunction

    task automatic idle();
        @(negedge clk);
        ifid_rs = '0; ifid_rt = '0; idex_rs = '0; idex_rt = '0;
        idex_mem_read = 0; exmem_rd = '0; memwb_rd = '0;
        exmem_reg_write = 0; memwb_reg_write = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_reset();
        #2;
        check("R1 fwd_a in reset", fwd_a, 0);
        check("R1 stall in reset", stall_fe, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); settle();
        check("R1 fwd_a", fwd_a, 0);
        check("R1 fwd_b", fwd_b, 0);
        check("R1 stall", stall_fe, 0);
        check("R1 bubble", bubble_id, 0);
    endtask

    task automatic t_exmem();
        idle();
        idex_rs = 5'd7; idex_rt = 5'd9;
        exmem_rd = 5'd7; exmem_reg_write = 1;
        settle();
        check("R2 fwd_a exmem", fwd_a, 2);
        check("R2 fwd_b untouched", fwd_b, 0);
        exmem_rd = 5'd9;
        settle();
        check("R2 fwd_b exmem", fwd_b, 2);
        check("R2 fwd_a back to rf", fwd_a, 0);
    endtask

    task automatic t_memwb();
        idle();
        idex_rs = 5'd12; idex_rt = 5'd12;
        memwb_rd = 5'd12; memwb_reg_write = 1;
        exmem_rd = 5'd3; exmem_reg_write = 1;
        settle();
        check("R3 fwd_a memwb", fwd_a, 1);
        check("R3 fwd_b memwb", fwd_b, 1);
    endtask

    task automatic t_priority();
        idle();
        idex_rs = 5'd20; idex_rt = 5'd20;
        exmem_rd = 5'd20; exmem_reg_write = 1;
        memwb_rd = 5'd20; memwb_reg_write = 1;
        settle();
        check("R4 fwd_a priority", fwd_a, 2);
        check("R4 fwd_b priority", fwd_b, 2);
        exmem_reg_write = 0;
        settle();
        check("R4 fallback to memwb", fwd_a, 1);
    endtask

    task automatic t_zero_and_nowrite();
        idle();
        idex_rs = 5'd0; idex_rt = 5'd0;
        exmem_rd = 5'd0; exmem_reg_write = 1;
        memwb_rd = 5'd0; memwb_reg_write = 1;
        settle();
        check("R5 r0 exmem ignored", fwd_a, 0);
        check("R5 r0 memwb ignored", fwd_b, 0);
        idex_rs = 5'd4; idex_rt = 5'd4;
        exmem_rd = 5'd4; exmem_reg_write = 0;
        memwb_rd = 5'd4; memwb_reg_write = 0;
        settle();
        check("R5 no write enable a", fwd_a, 0);
        check("R5 no write enable b", fwd_b, 0);
    endtask

    task automatic t_operands_differ();
        idle();
        idex_rs = 5'd5; idex_rt = 5'd6;
        exmem_rd = 5'd5; exmem_reg_write = 1;
        memwb_rd = 5'd6; memwb_reg_write = 1;
        settle();
        check("R9 fwd_a", fwd_a, ref_sel(idex_rs, exmem_rd, 1, memwb_rd, 1));
        check("R9 fwd_b", fwd_b, ref_sel(idex_rt, exmem_rd, 1, memwb_rd, 1));
    endtask

    task automatic t_loaduse();
        idle();
        idex_mem_read = 1; idex_rt = 5'd8; ifid_rs = 5'd8; ifid_rt = 5'd1;
        settle();
        check("R6 stall on first source", stall_fe, 1);
        check("R6 bubble on first source", bubble_id, 1);
        idle();
        idex_mem_read = 1; idex_rt = 5'd11; ifid_rs = 5'd2; ifid_rt = 5'd11;
        settle();
        check("R6 stall on second source", stall_fe, 1);
        check("R6 bubble on second source", bubble_id, 1);
        idle();
        idex_mem_read = 0; idex_rt = 5'd11; ifid_rs = 5'd11; ifid_rt = 5'd11;
        settle();
        check("R7 no load no stall", stall_fe, 0);
        check("R7 no load no bubble", bubble_id, 0);
        idex_mem_read = 1; ifid_rs = 5'd3; ifid_rt = 5'd4;
        settle();
        check("R7 load without match", stall_fe, 0);
    endtask

    task automatic t_one_cycle();
        idle();
        idex_mem_read = 1; idex_rt = 5'd14; ifid_rs = 5'd14;
        idex_rs = 5'd14; exmem_rd = 5'd14; exmem_reg_write = 1;
        settle();
        check("R8 stall first cycle", stall_fe, 1);
        check("R10 select during stall", fwd_a, 2);
        check("R10 select b during stall", fwd_b, 2);
        @(negedge clk); settle();
        check("R8 stall dropped", stall_fe, 0);
        check("R8 bubble dropped", bubble_id, 0);
        @(negedge clk); settle();
        check("R8 stall again", stall_fe, 1);
    endtask

    initial begin
        t_reset();
        t_exmem();
        t_memwb();
        t_priority();
        t_zero_and_nowrite();
        t_operands_differ();
        t_loaduse();
        t_one_cycle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule